// File: doc/BRIEF.md
# Processor Low-Power Mode Controller

This block decides which clocks of a small processor core run at any moment and how the core comes back from a sleep instruction. Software writes a small control word holding an I/O-stop bit, two clock-control bits and a bus-release-enable bit. When the core executes its sleep instruction it raises a one-cycle strobe. The control word present at that strobe selects one of three low-power states: plain sleep, system stop or idle. With the I/O-stop bit set and no sleep instruction, the core keeps running and only the on-chip peripherals are frozen.

Interrupt and NMI lines pass through two-flop synchronizers before they are used. NMI acts on its falling edge. A wake source counts only when its per-source enable is set. Peripheral sources can wake the core from plain sleep and from no other state. After a wake, the CPU clock enable stays low for two further cycles. On the first running cycle the block pulses a strobe and tells the core either to take an interrupt or to resume at the instruction after the sleep instruction. The core takes the interrupt for NMI, or when the global interrupt flag is set; otherwise it resumes.

Top module: `lpm_ctrl`

## Requirements
- R1: A source line whose per-source enable is 0 never ends any low-power state. The CPU clock enable stays 0 and halt stays 1.
- R2: On a wake, wake_take_irq is 1 when the wake source is NMI or when gie is 1. It is 0 when gie is 0 and an enabled interrupt line caused the wake.
- R3: While running, iostop = 1 gives io_ce = 0 and cpu_ce = 1. Writing iostop = 0 gives io_ce = 1 again.
- R4: A sleep strobe with iostop = 0 enters plain sleep regardless of the two clock bits: cpu_ce = 0 and io_ce = phi_ce = rfsh_ce = 1. Either an enabled external line or an enabled internal line wakes it.
- R5: A sleep strobe with iostop = 1 and the clock bits not equal to (ck_hi = 0, ck_lo = 1) enters system stop: cpu_ce = io_ce = 0 and phi_ce = rfsh_ce = 1. Internal lines cannot wake it.
- R6: A sleep strobe with iostop = 1, ck_hi = 0 and ck_lo = 1 enters idle, where all four clock enables are 0. Only an enabled external line or an NMI falling edge wakes it.
- R7: bus_rel_ok is 1 outside idle. Inside idle it holds the bus-release-enable value present at the sleep strobe, and later writes do not change it.
- R8: An input change made between edges leaves cpu_ce at 0 through the fourth following rising edge and makes it 1 after the fifth. wake_stb is 1 for exactly that first cycle.
- R9: halt and addr_ones are 1 in the three low-power states and 0 from the cycle after a wake is detected.
- R10: rst_n low at once forces cpu_ce, io_ce, phi_ce, rfsh_ce and bus_rel_ok to 1 and halt to 0, and clears the stored iostop.
- R11: NMI wakes only on a high-to-low transition. An NMI line already held low before the sleep strobe does not wake the core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock from the oscillator |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_iostop | input | 1 | Control word: freeze on-chip peripherals |
| cfg_ck_hi | input | 1 | Control word: upper clock-control bit |
| cfg_ck_lo | input | 1 | Control word: lower clock-control bit |
| cfg_brel | input | 1 | Control word: permit bus release during idle |
| slp_stb | input | 1 | One-cycle strobe from the sleep instruction |
| gie | input | 1 | Global interrupt enable flag |
| irq_ext | input | N_EXT | External interrupt request lines, active high, asynchronous |
| irq_ext_en | input | N_EXT | Per-source enables of the external lines |
| irq_int | input | N_INT | Peripheral interrupt request lines, active high |
| irq_int_en | input | N_INT | Per-source enables of the peripheral lines |
| nmi_n | input | 1 | Non-maskable interrupt, active low, asynchronous |
| cpu_ce | output | 1 | CPU clock enable |
| io_ce | output | 1 | On-chip peripheral clock enable |
| phi_ce | output | 1 | External clock pin enable |
| rfsh_ce | output | 1 | DRAM refresh enable |
| halt | output | 1 | Core is in a low-power state |
| addr_ones | output | 1 | Force address bus to all ones |
| bus_rel_ok | output | 1 | Permission to grant the bus to an external master |
| wake_stb | output | 1 | One-cycle pulse when execution restarts |
| wake_take_irq | output | 1 | 1: take interrupt; 0: resume at the next instruction |

## Verification
The hardest case to reach is the wake that must not happen. This covers a disabled line, a peripheral line in system stop or idle, and an NMI already low before sleep. A design that wrongly wakes and a correct design that stays asleep can look the same unless the sampling window covers the whole restart delay. The bench sweeps every low-power state against every line, both enable polarities and both gie values. The tested line has its enable cleared while all its neighbours have theirs set. After the same five-edge window used for real wakes, the bench checks that halt is still high and the CPU clock is still off.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [2:0] {
    ST_RUN     = 3'd0,
    ST_SLEEP   = 3'd1,
    ST_SYSSTOP = 3'd2,
    ST_IDLE    = 3'd3,
    ST_RESTART = 3'd4
  } lpm_state_e;

  function automatic lpm_state_e pick_low_state(input logic iostop,
                                                input logic ck_hi,
                                                input logic ck_lo);
    if (!iostop)              return ST_SLEEP;
    else if (!ck_hi && ck_lo) return ST_IDLE;
    else                      return ST_SYSSTOP;
  endfunction
endpackage

// File: rtl/lpm_sync.sv
module lpm_sync #(
  parameter int               WIDTH   = 1,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;
  logic [STAGES-1:0][WIDTH-1:0] stg_d;

  always_comb begin
    stg_d = {stg_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= {STAGES{RST_VAL}};
    else        stg_q <= stg_d;
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/lpm_wake_eval.sv
module lpm_wake_eval #(
  parameter int N_EXT = 3,
  parameter int N_INT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EXT-1:0] ext_s,
  input  logic [N_EXT-1:0] ext_en,
  input  logic [N_INT-1:0] int_s,
  input  logic [N_INT-1:0] int_en,
  input  logic             nmi_s_n,
  input  logic             gie,
  output logic             wake_sleep,
  output logic             wake_stop,
  output logic             take_irq
);
  logic nmi_prev_q;
  logic nmi_fall;
  logic ext_hit;
  logic int_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) nmi_prev_q <= 1'b1;
    else        nmi_prev_q <= nmi_s_n;
  end

  always_comb begin
    nmi_fall   = nmi_prev_q & ~nmi_s_n;
    ext_hit    = |(ext_s & ext_en);
    int_hit    = |(int_s & int_en);
    wake_sleep = nmi_fall | ext_hit | int_hit;
    wake_stop  = nmi_fall | ext_hit;
    take_irq   = nmi_fall | gie;
  end
endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
  import lpm_pkg::*;
#(
  parameter int RESTART_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slp_stb,
  input  logic iostop,
  input  logic ck_hi,
  input  logic ck_lo,
  input  logic brel,
  input  logic wake_sleep,
  input  logic wake_stop,
  input  logic take_irq,
  output logic cpu_ce,
  output logic phi_ce,
  output logic rfsh_ce,
  output logic halt,
  output logic bus_rel_ok,
  output logic wake_stb,
  output logic wake_take_irq
);
  localparam int CW = (RESTART_CYC > 1) ? $clog2(RESTART_CYC) : 1;
  localparam logic [CW-1:0] CNT_LOAD = CW'(RESTART_CYC - 1);

  lpm_state_e    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          brel_lat_q, brel_lat_d;
  logic          take_q, take_d;
  logic          stb_q, stb_d;

  always_comb begin
    st_d       = st_q;
    cnt_d      = cnt_q;
    brel_lat_d = brel_lat_q;
    take_d     = take_q;
    stb_d      = 1'b0;
    unique case (st_q)
      ST_RUN: begin
        if (slp_stb) begin
          st_d       = pick_low_state(iostop, ck_hi, ck_lo);
          brel_lat_d = brel;
        end
      end
      ST_SLEEP: begin
        if (wake_sleep) begin
          st_d   = ST_RESTART;
          cnt_d  = CNT_LOAD;
          take_d = take_irq;
        end
      end
      ST_SYSSTOP, ST_IDLE: begin
        if (wake_stop) begin
          st_d   = ST_RESTART;
          cnt_d  = CNT_LOAD;
          take_d = take_irq;
        end
      end
      ST_RESTART: begin
        if (cnt_q == '0) begin
          st_d  = ST_RUN;
          stb_d = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_RUN;
      cnt_q      <= '0;
      brel_lat_q <= 1'b0;
      take_q     <= 1'b0;
      stb_q      <= 1'b0;
    end else begin
      st_q       <= st_d;
      cnt_q      <= cnt_d;
      brel_lat_q <= brel_lat_d;
      take_q     <= take_d;
      stb_q      <= stb_d;
    end
  end

  always_comb begin
    cpu_ce        = (st_q == ST_RUN);
    phi_ce        = (st_q != ST_IDLE);
    rfsh_ce       = (st_q != ST_IDLE);
    halt          = (st_q == ST_SLEEP) || (st_q == ST_SYSSTOP) || (st_q == ST_IDLE);
    bus_rel_ok    = (st_q != ST_IDLE) || brel_lat_q;
    wake_stb      = stb_q;
    wake_take_irq = take_q;
  end
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl #(
  parameter int N_EXT       = 3,
  parameter int N_INT       = 2,
  parameter int SYNC_STAGES = 2,
  parameter int RESTART_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_iostop,
  input  logic             cfg_ck_hi,
  input  logic             cfg_ck_lo,
  input  logic             cfg_brel,
  input  logic             slp_stb,
  input  logic             gie,
  input  logic [N_EXT-1:0] irq_ext,
  input  logic [N_EXT-1:0] irq_ext_en,
  input  logic [N_INT-1:0] irq_int,
  input  logic [N_INT-1:0] irq_int_en,
  input  logic             nmi_n,
  output logic             cpu_ce,
  output logic             io_ce,
  output logic             phi_ce,
  output logic             rfsh_ce,
  output logic             halt,
  output logic             addr_ones,
  output logic             bus_rel_ok,
  output logic             wake_stb,
  output logic             wake_take_irq
);
  localparam int SW = N_EXT + N_INT + 1;

  logic          iostop_q, iostop_d;
  logic          ck_hi_q, ck_hi_d;
  logic          ck_lo_q, ck_lo_d;
  logic          brel_q, brel_d;
  logic [SW-1:0] raw_in, sync_out;
  logic          wake_sleep, wake_stop, take_irq;

  always_comb begin
    iostop_d = iostop_q;
    ck_hi_d  = ck_hi_q;
    ck_lo_d  = ck_lo_q;
    brel_d   = brel_q;
    if (cfg_we) begin
      iostop_d = cfg_iostop;
      ck_hi_d  = cfg_ck_hi;
      ck_lo_d  = cfg_ck_lo;
      brel_d   = cfg_brel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iostop_q <= 1'b0;
      ck_hi_q  <= 1'b0;
      ck_lo_q  <= 1'b0;
      brel_q   <= 1'b0;
    end else begin
      iostop_q <= iostop_d;
      ck_hi_q  <= ck_hi_d;
      ck_lo_q  <= ck_lo_d;
      brel_q   <= brel_d;
    end
  end

  assign raw_in = {nmi_n, irq_int, irq_ext};

  lpm_sync #(
    .WIDTH  (SW),
    .STAGES (SYNC_STAGES),
    .RST_VAL({1'b1, {(SW-1){1'b0}}})
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (raw_in),
    .q    (sync_out)
  );

  lpm_wake_eval #(
    .N_EXT(N_EXT),
    .N_INT(N_INT)
  ) u_wake (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_s     (sync_out[N_EXT-1:0]),
    .ext_en    (irq_ext_en),
    .int_s     (sync_out[N_EXT+N_INT-1:N_EXT]),
    .int_en    (irq_int_en),
    .nmi_s_n   (sync_out[SW-1]),
    .gie       (gie),
    .wake_sleep(wake_sleep),
    .wake_stop (wake_stop),
    .take_irq  (take_irq)
  );

  lpm_seq #(
    .RESTART_CYC(RESTART_CYC)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .slp_stb      (slp_stb),
    .iostop       (iostop_q),
    .ck_hi        (ck_hi_q),
    .ck_lo        (ck_lo_q),
    .brel         (brel_q),
    .wake_sleep   (wake_sleep),
    .wake_stop    (wake_stop),
    .take_irq     (take_irq),
    .cpu_ce       (cpu_ce),
    .phi_ce       (phi_ce),
    .rfsh_ce      (rfsh_ce),
    .halt         (halt),
    .bus_rel_ok   (bus_rel_ok),
    .wake_stb     (wake_stb),
    .wake_take_irq(wake_take_irq)
  );

  assign io_ce     = ~iostop_q;
  assign addr_ones = halt;
endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic slp_stb,
  input logic cpu_ce,
  input logic io_ce,
  input logic phi_ce,
  input logic rfsh_ce,
  input logic halt,
  input logic addr_ones,
  input logic bus_rel_ok,
  input logic wake_stb
);
  AST_CPU_NOT_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_ce && halt)); // R9

  AST_ADDR_WITH_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt) |-> addr_ones); // R9

  AST_IDLE_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !phi_ce |-> (!cpu_ce && !io_ce && !rfsh_ce)); // R6

  AST_SLEEP_FROM_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt) |-> $past(slp_stb)); // R4

  AST_RESTART_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_ce) |-> (!$past(cpu_ce, 2) && wake_stb)); // R8

  AST_STB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_stb |=> !wake_stb); // R8

  AST_BUS_OUTSIDE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    phi_ce |-> bus_rel_ok); // R7
endmodule

bind lpm_ctrl lpm_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .slp_stb   (slp_stb),
  .cpu_ce    (cpu_ce),
  .io_ce     (io_ce),
  .phi_ce    (phi_ce),
  .rfsh_ce   (rfsh_ce),
  .halt      (halt),
  .addr_ones (addr_ones),
  .bus_rel_ok(bus_rel_ok),
  .wake_stb  (wake_stb)
);

// File: tb/lpm_ctrl_tb.sv
module lpm_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we, cfg_iostop, cfg_ck_hi, cfg_ck_lo, cfg_brel;
  logic       slp_stb, gie, nmi_n;
  logic [2:0] irq_ext, irq_ext_en;
  logic [1:0] irq_int, irq_int_en;
  logic       cpu_ce, io_ce, phi_ce, rfsh_ce, halt, addr_ones;
  logic       bus_rel_ok, wake_stb, wake_take_irq;
  int         n_chk = 0;
  int         n_err = 0;
  bit         done  = 1'b0;

  always #2 clk = ~clk;

  lpm_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_iostop(cfg_iostop),
    .cfg_ck_hi(cfg_ck_hi), .cfg_ck_lo(cfg_ck_lo), .cfg_brel(cfg_brel),
    .slp_stb(slp_stb), .gie(gie), .irq_ext(irq_ext), .irq_ext_en(irq_ext_en),
    .irq_int(irq_int), .irq_int_en(irq_int_en), .nmi_n(nmi_n),
    .cpu_ce(cpu_ce), .io_ce(io_ce), .phi_ce(phi_ce), .rfsh_ce(rfsh_ce),
    .halt(halt), .addr_ones(addr_ones), .bus_rel_ok(bus_rel_ok),
    .wake_stb(wake_stb), .wake_take_irq(wake_take_irq)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cfg_we = 0; cfg_iostop = 0; cfg_ck_hi = 0; cfg_ck_lo = 0;
    cfg_brel = 0; slp_stb = 0; gie = 0; nmi_n = 1; irq_ext = 0; irq_int = 0;
    irq_ext_en = 0; irq_int_en = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic write_cfg(input logic io, input logic hi, input logic lo, input logic br);
    cfg_we = 1; cfg_iostop = io; cfg_ck_hi = hi; cfg_ck_lo = lo; cfg_brel = br;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic sleep_now();
    slp_stb = 1;
    @(negedge clk);
    slp_stb = 0;
  endtask

  // mode 0: plain sleep, 1: system stop, 2: idle; kind 0: ext, 1: int, 2: nmi
  task automatic trial(input int mode, input int kind, input int idx, input bit en, input bit g);
    bit wake_exp, take_exp;
    do_reset();
    irq_ext_en = (kind == 0) ? (en ? (3'b001 << idx) : ~(3'b001 << idx)) : 3'b111;
    irq_int_en = (kind == 1) ? (en ? (2'b01 << idx) : ~(2'b01 << idx)) : 2'b11;
    gie = g;
    case (mode)
      0: write_cfg(1'b0, 1'b0, 1'b1, 1'b0);
      1: write_cfg(1'b1, 1'b1, 1'b1, 1'b0);
      default: write_cfg(1'b1, 1'b0, 1'b1, 1'b0);
    endcase
    sleep_now();
    chk("R9", "halt entered", int'(halt), 1);
    chk("R9", "addr_ones entered", int'(addr_ones), 1);
    if (mode == 0) begin
      chk("R4", "sleep cpu/io/phi/rfsh", int'({cpu_ce, io_ce, phi_ce, rfsh_ce}), 4'b0111);
    end else if (mode == 1) begin
      chk("R5", "sysstop cpu/io/phi/rfsh", int'({cpu_ce, io_ce, phi_ce, rfsh_ce}), 4'b0011);
    end else begin
      chk("R6", "idle cpu/io/phi/rfsh", int'({cpu_ce, io_ce, phi_ce, rfsh_ce}), 4'b0000);
    end
    wake_exp = (kind == 2) || (en && (kind == 0 || mode == 0));
    take_exp = (kind == 2) || g;
    case (kind)
      0: irq_ext = 3'b001 << idx;
      1: irq_int = 2'b01 << idx;
      default: nmi_n = 1'b0;
    endcase
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R8", "cpu_ce still low after 4 edges", int'(cpu_ce), 0);
    chk(wake_exp ? "R9" : "R1", "halt after 4 edges", int'(halt), wake_exp ? 0 : 1);
    @(negedge clk);
    if (wake_exp) begin
      chk("R8", "cpu_ce after 5 edges", int'(cpu_ce), 1);
      chk("R8", "wake_stb first cycle", int'(wake_stb), 1);
      chk("R2", "wake_take_irq", int'(wake_take_irq), int'(take_exp));
      @(negedge clk);
      chk("R8", "wake_stb one cycle", int'(wake_stb), 0);
    end else begin
      chk(mode == 0 ? "R1" : (kind == 1 ? "R5" : "R1"), "no wake cpu_ce", int'(cpu_ce), 0);
      chk("R1", "no wake halt", int'(halt), 1);
    end
    irq_ext = 0; irq_int = 0; nmi_n = 1;
  endtask

  initial begin
    rst_n = 1'b0;
    do_reset();
    // R10 reset state
    chk("R10", "reset clocks", int'({cpu_ce, io_ce, phi_ce, rfsh_ce}), 4'b1111);
    chk("R10", "reset halt", int'(halt), 0);
    chk("R10", "reset bus_rel_ok", int'(bus_rel_ok), 1);

    // R3 I/O stop while running
    write_cfg(1'b1, 1'b0, 1'b0, 1'b0);
    chk("R3", "iostop io_ce", int'(io_ce), 0);
    chk("R3", "iostop cpu_ce", int'(cpu_ce), 1);
    write_cfg(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R3", "iostop cleared io_ce", int'(io_ce), 1);

    // near-exhaustive sweep
    for (int m = 0; m < 3; m++)
      for (int k = 0; k < 3; k++)
        for (int i = 0; i < ((k == 0) ? 3 : (k == 1) ? 2 : 1); i++)
          for (int e = 0; e < 2; e++)
            for (int g = 0; g < 2; g++)
              trial(m, k, i, e[0], g[0]);

    // R7 bus release in idle
    do_reset();
    write_cfg(1'b1, 1'b0, 1'b1, 1'b0);
    sleep_now();
    chk("R7", "idle without release", int'(bus_rel_ok), 0);
    do_reset();
    write_cfg(1'b1, 1'b0, 1'b1, 1'b1);
    sleep_now();
    chk("R7", "idle with release", int'(bus_rel_ok), 1);
    write_cfg(1'b1, 1'b0, 1'b1, 1'b0);
    chk("R7", "late write ignored", int'(bus_rel_ok), 1);

    // R10 reset during idle restores everything and clears iostop
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R10", "async reset clocks", int'({cpu_ce, io_ce, phi_ce, rfsh_ce}), 4'b1111);
    chk("R10", "async reset halt", int'(halt), 0);
    do_reset();

    // R11 NMI held low before sleep does not wake
    nmi_n = 1'b0;
    repeat (4) @(negedge clk);
    write_cfg(1'b0, 1'b0, 1'b0, 1'b0);
    sleep_now();
    repeat (8) @(negedge clk);
    chk("R11", "held NMI no wake", int'(halt), 1);
    nmi_n = 1'b1;
    repeat (3) @(negedge clk);
    nmi_n = 1'b0;
    repeat (5) @(negedge clk);
    chk("R11", "fresh NMI edge wakes", int'(cpu_ce), 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule